// File: doc/BRIEF.md
# Gray-Coded Counter Crossing with Handshake

This block keeps a binary event counter in a source clock domain and reports its value in a destination clock domain whose clock has no phase or frequency relation to the source. The counter steps up by one on an increment input and returns to zero on a clear input. Because a clear can arrive at any point in the range, successive counter values are not guaranteed to differ in a single bit. The Gray-coded word therefore never crosses on its own. It is held in a register and moves under a four-phase request/acknowledge exchange. Each control bit passes through a two-flop synchronizer.

The source side takes a snapshot whenever the exchange is idle and the Gray form of the count differs from the last word it sent. It raises request and keeps the word constant until acknowledge has come back and gone away again. The counter keeps running during a transfer, so the destination can skip values. It never sees a mixture of two values. The destination latches the word when the synchronized request rises and decodes it to binary in a register. It marks the new value with a one-cycle update strobe.

The output side carries no back-pressure. There is no ready input, and each update is simply presented for one destination cycle. A consumer that needs every reported value must sample each strobe.

Top module: `gcx_count_xfer`

## Requirements
- R1: While either reset is low, and after both resets are released with no increment or clear applied, `dst_count` is 0 and `dst_update` stays 0.
- R2: On each source clock edge, the source count becomes 0 when `src_clr` is 1 (even if `src_inc` is also 1), becomes count+1 when only `src_inc` is 1, and otherwise holds. A delivered value reflects this rule.
- R3: Every value shown on `dst_count` while `dst_update` is 1 is a value the source count actually took since the last reset.
- R4: `dst_update` is never high for two destination cycles in a row, and `dst_count` changes only in a cycle where `dst_update` is 1.
- R5: Once increment and clear stay low long enough for the handshake to settle, `dst_count` equals the final source count.
- R6: The held Gray word does not change during any source cycle in which request is high and was also high on the cycle before.
- R7: The destination raises acknowledge only while the source request is high, so each exchange runs request-up, acknowledge-up, request-down, acknowledge-down.
- R8: A clear applied at a mid-range count (for example 5, Gray 0111, to 0, Gray 0000) is delivered as 0, and no other value is reported.
- R9: No transfer starts, and no `dst_update` pulse occurs, when the source count equals the value last sent. A clear applied while the count is already 0 produces no update.
- R10: The count wraps from 2^W-1 to 0 on an increment. Both 2^W-1 and the wrapped 0 are delivered, where W is the counter width (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_inc | input | 1 | Increment the source count by one |
| src_clr | input | 1 | Clear the source count to zero (wins over increment) |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_count | output | W | Last delivered count, in binary |
| dst_update | output | 1 | One-cycle strobe marking a new `dst_count` |

## Verification
Short increment bursts that are followed by idle time show whether a plain count arrives intact. A count that stops at 2^W-1 and then takes one more step shows whether the wrap is handled. A clear from 5 exercises the multi-bit jump that would break a Gray-only crossing, and a simultaneous clear and increment shows which input wins. A clear while the count is already zero must produce no strobe. A long run of random increments with occasional clears, on clocks of unrelated periods, makes values arrive while transfers are in flight. During that run every reported value is checked against the history of source values, and the final settled value is compared with the bench's own count.

// File: rtl/gcx_pkg.sv
package gcx_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DROP = 2'd2
  } src_state_e;
endpackage

// File: rtl/gcx_sync2.sv
module gcx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], d_async};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/gcx_src_side.sv
module gcx_src_side
  import gcx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ack_async,
  output logic         req,
  output logic [W-1:0] hold,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  src_state_e   state;
  logic         ack_s;
  logic [W-1:0] gray_now;

  gcx_sync2 #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ack_async), .q(ack_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + ONE;
  end

  assign gray_now = cnt ^ (cnt >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SRC_IDLE;
      req   <= 1'b0;
      hold  <= '0;
    end else begin
      case (state)
        SRC_IDLE: if (gray_now != hold) begin
          hold  <= gray_now;
          req   <= 1'b1;
          state <= SRC_REQ;
        end
        SRC_REQ: if (ack_s) begin
          req   <= 1'b0;
          state <= SRC_DROP;
        end
        SRC_DROP: if (!ack_s) state <= SRC_IDLE;
        default: begin
          req   <= 1'b0;
          state <= SRC_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/gcx_dst_side.sv
module gcx_dst_side #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_async,
  input  logic [W-1:0] hold_async,
  output logic         ack,
  output logic [W-1:0] cap_gray,
  output logic         cap_stb
);
  logic req_s, req_d, req_rise;

  gcx_sync2 #(.STAGES(2)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_async), .q(req_s)
  );

  assign req_rise = req_s & ~req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d    <= 1'b0;
      ack      <= 1'b0;
      cap_gray <= '0;
      cap_stb  <= 1'b0;
    end else begin
      req_d   <= req_s;
      ack     <= req_s;
      cap_stb <= req_rise;
      if (req_rise) cap_gray <= hold_async;
    end
  end
endmodule

// File: rtl/gcx_gray_decode.sv
module gcx_gray_decode #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray,
  input  logic         stb_in,
  output logic [W-1:0] bin,
  output logic         stb_out
);
  logic [W-1:0] bin_c;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_c[i] = ^gray[W-1:i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin     <= '0;
      stb_out <= 1'b0;
    end else begin
      stb_out <= stb_in;
      if (stb_in) bin <= bin_c;
    end
  end
endmodule

// File: rtl/gcx_count_xfer.sv
module gcx_count_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_inc,
  input  logic         src_clr,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_count,
  output logic         dst_update
);
  logic         xfer_req, xfer_ack, cap_stb;
  logic [W-1:0] hold_gray, src_cnt, cap_gray;

  gcx_src_side #(.W(W)) u_src (
    .clk(src_clk), .rst_n(src_rst_n), .inc(src_inc), .clr(src_clr),
    .ack_async(xfer_ack), .req(xfer_req), .hold(hold_gray), .cnt(src_cnt)
  );

  gcx_dst_side #(.W(W)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n), .req_async(xfer_req),
    .hold_async(hold_gray), .ack(xfer_ack), .cap_gray(cap_gray),
    .cap_stb(cap_stb)
  );

  gcx_gray_decode #(.W(W)) u_dec (
    .clk(dst_clk), .rst_n(dst_rst_n), .gray(cap_gray), .stb_in(cap_stb),
    .bin(dst_count), .stb_out(dst_update)
  );
endmodule

// File: rtl/gcx_count_xfer_chk.sv
module gcx_count_xfer_chk #(
  parameter int W = 8
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         src_clr,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic         req,
  input logic         ack,
  input logic [W-1:0] hold,
  input logic [W-1:0] cnt,
  input logic [W-1:0] dst_count,
  input logic         dst_update
);
  assert_clear_wins_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_clr |=> (cnt == '0));

  assert_single_strobe_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_update |=> !dst_update);

  assert_count_moves_with_strobe_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (dst_count != $past(dst_count)) |-> dst_update);

  assert_hold_stable_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (req && $past(req)) |-> (hold == $past(hold)));

  assert_ack_after_req_R7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n || !src_rst_n)
    $rose(ack) |-> req);
endmodule

bind gcx_count_xfer gcx_count_xfer_chk #(.W(W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_clr(src_clr),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .req(xfer_req), .ack(xfer_ack),
  .hold(hold_gray), .cnt(src_cnt), .dst_count(dst_count), .dst_update(dst_update)
);

// File: tb/tb_gcx_count_xfer.sv
module tb_gcx_count_xfer;
  localparam int W = 8;
  localparam int NV = 1 << W;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic src_inc = 1'b0, src_clr = 1'b0;
  logic [W-1:0] dst_count;
  logic dst_update;

  int checks = 0, errors = 0, updates = 0;
  logic [W-1:0] model = '0;
  logic seen [NV];
  logic prev_upd = 1'b0;
  logic [W-1:0] prev_cnt = '0;

  always #4 src_clk = ~src_clk;
  initial begin #3; forever #6.5 dst_clk = ~dst_clk; end

  gcx_count_xfer #(.W(W)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_inc(src_inc), .src_clr(src_clr),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(dst_count), .dst_update(dst_update)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench model of the source count
  always @(posedge src_clk) begin
    if (!src_rst_n) begin
      model = '0;
      for (int i = 0; i < NV; i++) seen[i] = 1'b0;
      seen[0] = 1'b1;
    end else begin
      if (src_clr) model = '0;
      else if (src_inc) model = model + 1'b1;
      seen[model] = 1'b1;
    end
  end

  // destination monitor
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_update) begin
        updates++;
        check(seen[dst_count], "R3 reported value was a real count", int'(dst_count), -1);
        if (prev_upd) check(1'b0, "R4 strobe lasts one cycle", 2, 1);
      end else if (dst_count != prev_cnt) begin
        check(1'b0, "R4 count changed without strobe", int'(dst_count), int'(prev_cnt));
      end
      prev_upd = dst_update;
      prev_cnt = dst_count;
    end
  end

  task automatic settle();
    src_inc = 1'b0; src_clr = 1'b0;
    repeat (40) @(negedge dst_clk);
  endtask

  task automatic incs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge src_clk); src_inc = 1'b1;
    end
    @(negedge src_clk); src_inc = 1'b0;
  endtask

  task automatic do_clear(input bit with_inc);
    @(negedge src_clk); src_clr = 1'b1; src_inc = with_inc;
    @(negedge src_clk); src_clr = 1'b0; src_inc = 1'b0;
  endtask

  task automatic t_reset();
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    repeat (5) @(negedge dst_clk);
    check(dst_count == 0 && dst_update == 0, "R1 outputs in reset", int'(dst_count), 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    repeat (30) @(negedge dst_clk);
    check(dst_count == 0, "R1 count after reset", int'(dst_count), 0);
    check(updates == 0, "R1 no strobe after reset", updates, 0);
  endtask

  task automatic t_burst();
    incs(10); settle();
    check(dst_count == 10, "R5 burst of ten delivered", int'(dst_count), 10);
    check(updates > 0, "R4 strobes seen", updates, 1);
  endtask

  task automatic t_clear_mid();
    int base;
    do_clear(1'b0); settle();
    incs(5); settle();
    check(dst_count == 5, "R8 reached 5", int'(dst_count), 5);
    base = updates;
    do_clear(1'b0); settle();
    check(dst_count == 0, "R8 clear from 5 gives 0", int'(dst_count), 0);
    check(updates - base == 1, "R8 one update for clear", updates - base, 1);
  endtask

  task automatic t_clr_inc();
    incs(3); settle();
    do_clear(1'b1); settle();
    check(dst_count == 0, "R2 clear wins over increment", int'(dst_count), 0);
  endtask

  task automatic t_no_change();
    int base = updates;
    do_clear(1'b0); settle();
    check(updates == base, "R9 clear at zero gives no update", updates - base, 0);
    check(dst_count == 0, "R9 count stays zero", int'(dst_count), 0);
  endtask

  task automatic t_wrap();
    incs(NV - 1); settle();
    check(dst_count == NV - 1, "R10 top value delivered", int'(dst_count), NV - 1);
    incs(1); settle();
    check(dst_count == 0, "R10 wrap to zero delivered", int'(dst_count), 0);
    incs(2); settle();
    check(dst_count == 2, "R2 count steps by one", int'(dst_count), 2);
  endtask

  task automatic t_random();
    int base = updates;
    for (int i = 0; i < 3000; i++) begin
      @(negedge src_clk);
      src_inc = ($urandom_range(1) == 1);
      src_clr = ($urandom_range(39) == 0);
    end
    settle();
    check(dst_count == model, "R5 random run settles to source count", int'(dst_count), int'(model));
    check(updates - base > 20, "R3 many transfers in random run", updates - base, 21);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_burst();
    t_clear_mid();
    t_clr_inc();
    t_no_change();
    t_wrap();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule